// File: doc/BRIEF.md
# Raw-Bit Word Assembler with One-Block SHA-256 Conditioner

This block gathers a stream of sampled entropy bits, one per clock, into a 440-bit raw word and then conditions that word with a single SHA-256 compression. A trigger pulse starts a run. Collection then takes exactly 440 clocks. The block pads the 55 collected bytes into one 512-bit message block and hashes it at one round per clock. When the hash finishes, the raw word and the 256-bit digest are presented side by side with a done flag.

The message length is fixed at the largest size that still fits a single SHA-256 block. Because of this, the padding is a constant tail and every run needs exactly one compression. The latency from trigger to result is therefore the same on every run. A host or downstream consumer pulses the trigger and waits for done. It then reads both values, which stay frozen until it starts the next run.

Top module: `trng_cond_top`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active-low), the block returns to idle, and afterwards `done_o` is 0, `raw_word_o` is all zeros and `digest_o` is all zeros.
- R2: A trigger accepted at edge T clears the bit counter and the raw word. The raw bit is then sampled at each of the 440 rising edges T+1 through T+440.
- R3: The first sampled bit lands in `raw_word_o[439]` and the last in `raw_word_o[0]`. This makes the first bit the most significant bit of message byte 0.
- R4: `digest_o` equals SHA-256 over the 512-bit block formed as raw word, then byte 0x80, then the 64-bit big-endian length 440 (0x1B8). The digest word H0 occupies bits 255:224 and H7 occupies bits 31:0.
- R5: `done_o` rises at the 66th rising edge after the edge that samples the 440th bit. One edge loads the block, 64 edges run the rounds, and one edge adds the initial values.
- R6: A trigger that arrives while a run is collecting or hashing is ignored. The run's raw word, digest and done timing are unchanged.
- R7: While `done_o` is high and no trigger arrives, `done_o`, `raw_word_o` and `digest_o` hold their values. An accepted trigger drops `done_o` at the accepting edge.
- R8: `raw_bit_i` has no effect outside the collection window. This covers idle, hashing and done.
- R9: A trigger is accepted both from idle after reset and from the done state. One edge after acceptance, `raw_word_o` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Run-start pulse, honoured only in idle or done |
| raw_bit_i | input | 1 | Sampled entropy bit, one per clock |
| raw_word_o | output | 440 | Assembled raw word, first bit at the MSB |
| digest_o | output | 256 | SHA-256 digest of the padded raw word |
| done_o | output | 1 | High while the run's results are valid |

## Verification
Counted from the edge that accepts the trigger, the raw word is cleared one edge later. The 440th bit is taken at edge T+440, and done rises at edge T+506. The bench drives inputs and samples outputs only on falling edges. It counts rising edges from the acceptance, so it checks that done is still low after edge T+505 and high after edge T+506. Raw word and digest are compared at that same point against a word the bench built from its own bit pattern and a SHA-256 computed in the bench. Stray triggers and toggling bits are injected mid-collection and mid-hash. Holding and stability are then observed over further falling-edge samples in the done state.

// File: rtl/trng_cond_pkg.sv
package trng_cond_pkg;

  localparam int RAW_BITS   = 440;
  localparam int BLOCK_BITS = 512;
  localparam int LEN_BITS   = 64;
  localparam int PAD_BITS   = BLOCK_BITS - RAW_BITS - LEN_BITS;
  localparam int WORD_W     = 32;
  localparam int ROUNDS     = 64;
  localparam int DIG_WORDS  = 8;
  localparam int DIG_W      = WORD_W * DIG_WORDS;
  localparam int SCHED_WORDS = BLOCK_BITS / WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FILL = 3'd1,
    ST_LOAD = 3'd2,
    ST_HASH = 3'd3,
    ST_DONE = 3'd4
  } run_state_t;

  localparam word_t SHA_K [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam word_t SHA_IV [DIG_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sig_big0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t sig_big1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sig_sm0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sig_sm1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

endpackage

// File: rtl/raw_bit_collector.sv
module raw_bit_collector #(
  parameter int NBITS = 440,
  localparam int CW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] word_o,
  output logic             last_o
);

  logic [NBITS-1:0] word_q, word_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             upd;

  assign last_o = en_i && (cnt_q == CW'(NBITS - 1));
  assign upd    = clr_i || en_i;
  assign word_o = word_q;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (en_i) begin
      word_d = {word_q[NBITS-2:0], bit_i};
      cnt_d  = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2: the counter never passes the last bit position
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NBITS - 1));

  // R3: each sampled bit enters at the LSB end, older bits move up
  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> (word_q[0] == $past(bit_i)) &&
                         (word_q[NBITS-1:1] == $past(word_q[NBITS-2:0])));

  // R8: no update without clear or enable
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(word_q));

endmodule

// File: rtl/sha_msg_window.sv
module sha_msg_window
  import trng_cond_pkg::*;
#(
  parameter int NWORDS = 16,
  localparam int BB    = NWORDS * WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [BB-1:0] block_i,
  output word_t         wt_o
);

  word_t w_q [NWORDS];
  word_t w_d [NWORDS];
  word_t w_new;

  assign w_new = sig_sm1(w_q[NWORDS-2]) + w_q[NWORDS-7] + sig_sm0(w_q[1]) + w_q[0];
  assign wt_o  = w_q[0];

  always_comb begin
    for (int j = 0; j < NWORDS; j++) begin
      w_d[j] = w_q[j];
    end
    if (load_i) begin
      for (int j = 0; j < NWORDS; j++) begin
        w_d[j] = block_i[BB-1-WORD_W*j -: WORD_W];
      end
    end else if (step_i) begin
      for (int j = 0; j < NWORDS-1; j++) begin
        w_d[j] = w_q[j+1];
      end
      w_d[NWORDS-1] = w_new;
    end
  end

  generate
    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          w_q[g] <= '0;
        end else if (load_i || step_i) begin
          w_q[g] <= w_d[g];
        end
      end
    end
  endgenerate

  // R4: the window slides by one word per round
  p_window_slide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (w_q[0] == $past(w_q[1])));

  // R4: a load places the block's first word at the head
  p_window_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (w_q[0] == $past(block_i[BB-1 -: WORD_W])));

endmodule

// File: rtl/sha_round_core.sv
module sha_round_core
  import trng_cond_pkg::*;
#(
  parameter int NROUNDS = 64,
  localparam int RW     = $clog2(NROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  word_t            wt_i,
  output logic             step_o,
  output logic             fin_o,
  output logic [DIG_W-1:0] digest_o
);

  word_t            v_q [DIG_WORDS];
  word_t            v_d [DIG_WORDS];
  logic             act_q, act_d;
  logic             fin_q, fin_d;
  logic [RW-1:0]    rnd_q, rnd_d;
  logic [DIG_W-1:0] dig_q, dig_d;
  logic             last_rnd;
  word_t            t1, t2;

  assign last_rnd = act_q && (rnd_q == RW'(NROUNDS - 1));
  assign t1 = v_q[7] + sig_big1(v_q[4]) + f_choose(v_q[4], v_q[5], v_q[6])
            + SHA_K[rnd_q] + wt_i;
  assign t2 = sig_big0(v_q[0]) + f_major(v_q[0], v_q[1], v_q[2]);

  assign step_o   = act_q;
  assign fin_o    = fin_q;
  assign digest_o = dig_q;

  always_comb begin
    for (int j = 0; j < DIG_WORDS; j++) begin
      v_d[j] = v_q[j];
    end
    act_d = act_q;
    fin_d = 1'b0;
    rnd_d = rnd_q;
    dig_d = dig_q;
    if (load_i) begin
      for (int j = 0; j < DIG_WORDS; j++) begin
        v_d[j] = SHA_IV[j];
      end
      act_d = 1'b1;
      rnd_d = '0;
    end else if (act_q) begin
      v_d[0] = t1 + t2;
      v_d[1] = v_q[0];
      v_d[2] = v_q[1];
      v_d[3] = v_q[2];
      v_d[4] = v_q[3] + t1;
      v_d[5] = v_q[4];
      v_d[6] = v_q[5];
      v_d[7] = v_q[6];
      rnd_d  = rnd_q + 1'b1;
      if (last_rnd) begin
        act_d = 1'b0;
        fin_d = 1'b1;
      end
    end
    if (fin_q) begin
      for (int j = 0; j < DIG_WORDS; j++) begin
        dig_d[DIG_W-1-WORD_W*j -: WORD_W] = SHA_IV[j] + v_q[j];
      end
    end
  end

  generate
    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_var
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[g] <= '0;
        end else if (load_i || act_q) begin
          v_q[g] <= v_d[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      fin_q <= 1'b0;
      rnd_q <= '0;
    end else begin
      act_q <= act_d;
      fin_q <= fin_d;
      rnd_q <= rnd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dig_q <= '0;
    end else if (fin_q) begin
      dig_q <= dig_d;
    end
  end

  // R5: the final add follows directly on the last round
  p_fin_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> $past(act_q) && ($past(rnd_q) == RW'(NROUNDS - 1)));

  // R6: the controller never reloads a busy engine
  p_no_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !act_q && !fin_q);

  // R7: the digest only moves on the final add
  p_digest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_q |=> $stable(dig_q));

endmodule

// File: rtl/trng_cond_top.sv
module trng_cond_top
  import trng_cond_pkg::*;
#(
  parameter int RAW_W  = RAW_BITS,
  parameter int HASH_W = DIG_W,
  localparam int PAD_W = BLOCK_BITS - RAW_W - LEN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              raw_bit_i,
  output logic [RAW_W-1:0]  raw_word_o,
  output logic [HASH_W-1:0] digest_o,
  output logic              done_o
);

  run_state_t            st_q, st_d;
  logic                  trig_ok;
  logic                  col_en, col_last;
  logic                  eng_load, eng_step, eng_fin;
  logic [BLOCK_BITS-1:0] msg_block;
  word_t                 wt;
  logic [RAW_W-1:0]      word;
  logic [DIG_W-1:0]      dig;

  assign trig_ok  = trig_i && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign col_en   = (st_q == ST_FILL);
  assign eng_load = (st_q == ST_LOAD);
  assign msg_block = {word, 1'b1, {(PAD_W-1){1'b0}}, LEN_BITS'(RAW_W)};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (trig_ok)  st_d = ST_FILL;
      ST_FILL:          if (col_last) st_d = ST_LOAD;
      ST_LOAD:                        st_d = ST_HASH;
      ST_HASH:          if (eng_fin)  st_d = ST_DONE;
      default:                        st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  raw_bit_collector #(.NBITS(RAW_W)) u_collect (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (trig_ok),
    .en_i   (col_en),
    .bit_i  (raw_bit_i),
    .word_o (word),
    .last_o (col_last)
  );

  sha_msg_window #(.NWORDS(SCHED_WORDS)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (eng_load),
    .step_i  (eng_step),
    .block_i (msg_block),
    .wt_o    (wt)
  );

  sha_round_core #(.NROUNDS(ROUNDS)) u_rounds (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (eng_load),
    .wt_i     (wt),
    .step_o   (eng_step),
    .fin_o    (eng_fin),
    .digest_o (dig)
  );

  assign raw_word_o = word;
  assign digest_o   = HASH_W'(dig);
  assign done_o     = (st_q == ST_DONE);

  // R7: results hold until a trigger is taken
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !trig_i) |=> done_o && $stable(raw_word_o) && $stable(digest_o));

  // R6: a trigger during hashing does not restart collection
  p_hash_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HASH && trig_i) |=> (st_q == ST_HASH) || (st_q == ST_DONE));

  // R5: done is entered only from hashing
  p_done_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(st_q) == ST_HASH);

  // R9: an accepted trigger leaves the word cleared
  p_trig_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> (raw_word_o == '0) && !done_o);

endmodule

// File: tb/trng_cond_top_tb_top.sv
`timescale 1ns/1ps
module trng_cond_top_tb_top;
  import trng_cond_pkg::*;

  localparam int NB = RAW_BITS;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            trig_i;
  logic            raw_bit_i;
  logic [NB-1:0]   raw_word_o;
  logic [255:0]    digest_o;
  logic            done_o;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  trng_cond_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig_i),
    .raw_bit_i  (raw_bit_i),
    .raw_word_o (raw_word_o),
    .digest_o   (digest_o),
    .done_o     (done_o)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_hash(input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] h [8];
    logic [31:0] a, b, c, d, e, f, g, hh, x1, x2;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int j = 0; j < 8; j++) h[j] = SHA_IV[j];
    a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4]; f = h[5]; g = h[6]; hh = h[7];
    for (int t = 0; t < 64; t++) begin
      x1 = hh + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + SHA_K[t] + w[t];
      x2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
      hh = g; g = f; f = e; e = d + x1; d = c; c = b; b = a; a = x1 + x2;
    end
    return {h[0]+a, h[1]+b, h[2]+c, h[3]+d, h[4]+e, h[5]+f, h[6]+g, h[7]+hh};
  endfunction

  task automatic check(input logic ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] make_pattern(input int pat);
    logic [NB-1:0] v;
    logic [31:0]   s;
    s = 32'h1234_5678 + 32'(pat) * 32'h9e37_79b9;
    for (int i = 0; i < NB; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      case (pat)
        0:       v[NB-1-i] = 1'b0;
        1:       v[NB-1-i] = 1'b1;
        2:       v[NB-1-i] = i[0];
        3:       v[NB-1-i] = (i == 0);
        4:       v[NB-1-i] = (i == NB-1);
        default: v[NB-1-i] = s[0];
      endcase
    end
    return v;
  endfunction

  task automatic do_run(input int pat, input logic inject);
    logic [NB-1:0]  exp_w;
    logic [255:0]   exp_d;
    logic [NB-1:0]  held_w;
    logic [255:0]   held_d;
    exp_w = make_pattern(pat);
    exp_d = ref_hash({exp_w, 8'h80, 64'd440});
    trig_i    = 1'b1;
    raw_bit_i = 1'b1;
    @(posedge clk);                       // edge T accepts
    @(negedge clk);
    trig_i = 1'b0;
    check(raw_word_o == '0, "R9 word cleared after accept", 512'(raw_word_o), 512'd0);
    check(done_o == 1'b0, "R7 done drops on accept", 512'(done_o), 512'd0);
    for (int i = 0; i < NB; i++) begin
      raw_bit_i = exp_w[NB-1-i];
      trig_i    = inject && (i == 200);   // R6 stray trigger mid-collection
      @(posedge clk);
      @(negedge clk);
    end
    trig_i = 1'b0;
    for (int k = 1; k <= 66; k++) begin
      raw_bit_i = ~raw_bit_i;             // R8 bits ignored while hashing
      trig_i    = inject && (k == 20);    // R6 stray trigger mid-hash
      @(posedge clk);
      @(negedge clk);
      trig_i = 1'b0;
      if (k == 65) check(done_o == 1'b0, "R5 done low one edge early", 512'(done_o), 512'd0);
      if (k == 66) check(done_o == 1'b1, "R5 done at 66th edge", 512'(done_o), 512'd1);
    end
    check(raw_word_o == exp_w, "R2 R3 raw word", 512'(raw_word_o), 512'(exp_w));
    check(digest_o == exp_d, "R4 digest", 512'(digest_o), 512'(exp_d));
    held_w = raw_word_o;
    held_d = digest_o;
    for (int k = 0; k < 12; k++) begin
      raw_bit_i = k[0];
      @(posedge clk);
      @(negedge clk);
    end
    check(done_o == 1'b1, "R7 done held", 512'(done_o), 512'd1);
    check(raw_word_o == held_w, "R7 R8 word held in done", 512'(raw_word_o), 512'(held_w));
    check(digest_o == held_d, "R7 digest held in done", 512'(digest_o), 512'(held_d));
  endtask

  initial begin
    rst_n     = 1'b0;
    trig_i    = 1'b0;
    raw_bit_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(done_o == 1'b0, "R1 done after reset", 512'(done_o), 512'd0);
    check(raw_word_o == '0, "R1 word after reset", 512'(raw_word_o), 512'd0);
    check(digest_o == '0, "R1 digest after reset", 512'(digest_o), 512'd0);
    for (int k = 0; k < 10; k++) begin    // R8 idle toggling
      raw_bit_i = ~raw_bit_i;
      @(posedge clk);
      @(negedge clk);
    end
    check(raw_word_o == '0, "R8 idle bits ignored", 512'(raw_word_o), 512'd0);
    for (int p = 0; p < 8; p++) begin
      do_run(p, (p == 2) || (p == 6));
    end
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(done_o == 1'b0, "R1 done after mid-life reset", 512'(done_o), 512'd0);
    check(raw_word_o == '0, "R1 word after mid-life reset", 512'(raw_word_o), 512'd0);
    do_run(9, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule